// File: doc/BRIEF.md
# ADC Register Front-End with Power-Up Settling Guard

This block sits between a simple 32-bit register bus and an 8-channel, 10-bit conversion core. Software selects a channel, asks for a conversion, polls a completion flag and reads back the result together with the channel that was actually sampled. Toward the core the block drives a power enable, a one-cycle start pulse and a channel select. It takes back a done strobe with the result. In this project the core is a fixed-latency model that captures an input code when a conversion is launched.

The power-up register turns the converter on and off. A conversion request is never passed to the core until power has been held for a settling period of at least `SETTLE_CYC` clock cycles. A request made earlier, including one made while the converter is off, stays pending and launches once settling is over. The channel used by a conversion is latched at launch and reported in its own register. Software may therefore rewrite the configuration while a conversion runs without corrupting the report.

The sequencer has four states. `ST_OFF`: power is off. `ST_SETTLE`: the settling count is running. `ST_IDLE`: the converter is powered and ready. `ST_BUSY`: a conversion is in flight. The transitions are:
- OFF→SETTLE when the power bit is set.
- SETTLE→IDLE when the count expires.
- IDLE→BUSY on launch, which happens when the start bit is set.
- BUSY→IDLE on the done strobe.
- Any state→OFF when the power bit is cleared.

Register map (byte offsets on `bus_addr`):

| Offset | Contents |
|--------|----------|
| 0x00 | Configuration: channel in bits [2:0], start in bit 4, single-shot in bit 5 |
| 0x04 | Result in bits [9:0] |
| 0x08 | Completion flag in bit 0 |
| 0x0C | Sampled channel in bits [2:0] |
| 0x10 | Power enable in bit 0 |

Top module: `adcfe_top`

## Requirements
- R1: After reset every register reads 0, and `core_pwr` and `core_start` are 0.
- R2: Configuration (0x00: channel bits [2:0], start bit 4, single-shot bit 5) and power (0x10: bit 0) read back what was written. All other bits read 0, and any offset outside 0x00/0x04/0x08/0x0C/0x10 reads 0.
- R3: `core_start` is never asserted until power has been on for at least `SETTLE_CYC` (6) cycles. A start that is already pending when power is written launches in the cycle after the 7th rising edge that follows the power write.
- R4: The completion flag (0x08 bit 0) clears when a conversion launches and sets when the core reports done. At that same edge the result (0x04 bits [9:0]) takes the code captured at launch, and 0x0C takes the launched channel.
- R5: In single-shot mode (bit 5 = 1) the start bit clears when the conversion launches.
- R6: In continuous mode (bit 5 = 0) the start bit stays set and a new conversion launches after each completes. Clearing the start bit stops further launches.
- R7: The sampled channel (0x0C) and `core_chan` during a conversion are the channel at launch, even if the configuration is rewritten mid-conversion.
- R8: Writing 0 to the power register drops `core_pwr` and aborts a conversion in flight without setting the completion flag. Powering up again requires a fresh settling period.
- R9: Bus writes to the result, completion and sampled-channel offsets, and to unmapped offsets, change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Register byte offset |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| sample_in | input | 10 | Analog code seen by the converter model, captured at launch |
| core_pwr | output | 1 | Power enable to the converter |
| core_start | output | 1 | One-cycle conversion start |
| core_chan | output | 3 | Channel select to the converter |

## Verification
Three situations are hard to reach from the ports, and the stimulus is built to reach each one:
- **Pending start across settling.** The start bit is written while the converter is still off, then power is written. A monitor measures the exact number of cycles from the power write to the first start pulse.
- **Channel reporting.** The configuration channel is rewritten while a conversion is in flight, to show that the sampled-channel report and `core_chan` do not follow the rewrite.
- **Abort by power-down.** Power is removed in the middle of a conversion. The bench then waits past the core latency to show that the completion flag stays clear, and measures the settling gap again after power is restored.

// File: rtl/adcfe_pkg.sv
package adcfe_pkg;

    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_SETTLE = 2'd1,
        ST_IDLE   = 2'd2,
        ST_BUSY   = 2'd3
    } fe_state_e;

    localparam int unsigned OFS_CFG  = 32'h00;
    localparam int unsigned OFS_DATA = 32'h04;
    localparam int unsigned OFS_EOC  = 32'h08;
    localparam int unsigned OFS_SAMP = 32'h0C;
    localparam int unsigned OFS_PWR  = 32'h10;

    localparam int unsigned START_BIT  = 4;
    localparam int unsigned SINGLE_BIT = 5;

endpackage

// File: rtl/adcfe_conv_stub.sv
module adcfe_conv_stub #(
    parameter int LATENCY = 12,
    parameter int CH_W    = 3,
    parameter int RES_W   = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr,
    input  logic             start,
    input  logic [CH_W-1:0]  chan,
    input  logic [RES_W-1:0] sample,
    output logic             done,
    output logic [RES_W-1:0] res,
    output logic [CH_W-1:0]  res_chan
);
    localparam int CNT_W = $clog2(LATENCY + 1);

    logic             busy_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q   <= 1'b0;
            cnt_q    <= '0;
            res      <= '0;
            res_chan <= '0;
        end else if (!pwr) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (start) begin
            busy_q   <= 1'b1;
            cnt_q    <= CNT_W'(LATENCY - 1);
            res      <= sample;
            res_chan <= chan;
        end else if (busy_q) begin
            if (cnt_q == '0) busy_q <= 1'b0;
            else             cnt_q  <= cnt_q - 1'b1;
        end
    end

    assign done = busy_q && (cnt_q == '0) && pwr;

    // R4: done is a single-cycle strobe
    a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: rtl/adcfe_seq.sv
module adcfe_seq
    import adcfe_pkg::*;
#(
    parameter int SETTLE_CYC = 6
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      pwr_en,
    input  logic      start_req,
    input  logic      conv_done,
    output logic      launch,
    output fe_state_e state
);
    localparam int CNT_W = $clog2(SETTLE_CYC + 1);
    localparam int AGE_W = $clog2(SETTLE_CYC + 2);

    fe_state_e        state_d;
    logic [CNT_W-1:0] settle_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= state_d;
    end

    // next state
    always_comb begin
        state_d = state;
        unique case (state)
            ST_OFF:    if (pwr_en) state_d = ST_SETTLE;
            ST_SETTLE: begin
                if (!pwr_en)                                state_d = ST_OFF;
                else if (settle_q == CNT_W'(SETTLE_CYC - 1)) state_d = ST_IDLE;
            end
            ST_IDLE: begin
                if (!pwr_en)        state_d = ST_OFF;
                else if (start_req) state_d = ST_BUSY;
            end
            ST_BUSY: begin
                if (!pwr_en)        state_d = ST_OFF;
                else if (conv_done) state_d = ST_IDLE;
            end
            default: state_d = ST_OFF;
        endcase
    end

    // settling counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   settle_q <= '0;
        else if (state != ST_SETTLE)  settle_q <= '0;
        else                          settle_q <= settle_q + 1'b1;
    end

    // outputs
    always_comb begin
        launch = 1'b0;
        unique case (state)
            ST_IDLE: launch = pwr_en && start_req;
            default: launch = 1'b0;
        endcase
    end

    // checker: cycles since power came on, saturating
    logic [AGE_W-1:0] pwr_age_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               pwr_age_q <= '0;
        else if (!pwr_en)         pwr_age_q <= '0;
        else if (pwr_age_q != '1) pwr_age_q <= pwr_age_q + 1'b1;
    end

    // R3: no launch before the settling period has elapsed
    a_r3_settled_launch: assert property (@(posedge clk) disable iff (!rst_n)
        launch |-> (int'(pwr_age_q) >= SETTLE_CYC));

    // R8: loss of power returns the sequencer to OFF
    a_r8_power_off: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwr_en) |=> (state == ST_OFF));

endmodule

// File: rtl/adcfe_regs.sv
module adcfe_regs
    import adcfe_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int CH_W   = 3,
    parameter int RES_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              launch,
    input  logic              done,
    input  logic [RES_W-1:0]  res,
    input  logic [CH_W-1:0]   res_chan,
    output logic [CH_W-1:0]   cfg_chan,
    output logic              cfg_start,
    output logic              cfg_single,
    output logic              pwr_en
);
    localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(OFS_CFG);
    localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFS_DATA);
    localparam logic [ADDR_W-1:0] A_EOC  = ADDR_W'(OFS_EOC);
    localparam logic [ADDR_W-1:0] A_SAMP = ADDR_W'(OFS_SAMP);
    localparam logic [ADDR_W-1:0] A_PWR  = ADDR_W'(OFS_PWR);

    logic             eoc_q;
    logic [RES_W-1:0] data_q;
    logic [CH_W-1:0]  samp_q;
    logic             cfg_wr;
    logic             pwr_wr;
    logic             unused_wbits;

    assign cfg_wr       = bus_we && (bus_addr == A_CFG);
    assign pwr_wr       = bus_we && (bus_addr == A_PWR);
    assign unused_wbits = ^bus_wdata;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_chan   <= '0;
            cfg_start  <= 1'b0;
            cfg_single <= 1'b0;
        end else if (cfg_wr) begin
            cfg_chan   <= bus_wdata[CH_W-1:0];
            cfg_start  <= bus_wdata[START_BIT];
            cfg_single <= bus_wdata[SINGLE_BIT];
        end else if (launch && cfg_single) begin
            cfg_start <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      pwr_en <= 1'b0;
        else if (pwr_wr) pwr_en <= bus_wdata[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eoc_q  <= 1'b0;
            data_q <= '0;
            samp_q <= '0;
        end else if (launch) begin
            eoc_q <= 1'b0;
        end else if (done) begin
            eoc_q  <= 1'b1;
            data_q <= res;
            samp_q <= res_chan;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CFG: begin
                bus_rdata[CH_W-1:0]  = cfg_chan;
                bus_rdata[START_BIT]  = cfg_start;
                bus_rdata[SINGLE_BIT] = cfg_single;
            end
            A_DATA:  bus_rdata[RES_W-1:0] = data_q;
            A_EOC:   bus_rdata[0]          = eoc_q;
            A_SAMP:  bus_rdata[CH_W-1:0]  = samp_q;
            A_PWR:   bus_rdata[0]          = pwr_en;
            default: bus_rdata = '0;
        endcase
    end

    // R4: flag clears at launch, sets on done
    a_r4_eoc_clear: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> !eoc_q);
    a_r4_eoc_set: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> eoc_q);

    // R5: single-shot start self-clears at launch
    a_r5_single_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (launch && cfg_single && !cfg_wr) |=> !cfg_start);

    // R9: bus write to result offset leaves result untouched
    a_r9_ro_data: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_DATA && !done) |=> $stable(data_q));

endmodule

// File: rtl/adcfe_top.sv
module adcfe_top
    import adcfe_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 32,
    parameter int NUM_CH     = 8,
    parameter int RES_W      = 10,
    parameter int SETTLE_CYC = 6,
    parameter int CONV_LAT   = 12,
    localparam int CH_W      = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [RES_W-1:0]  sample_in,
    output logic              core_pwr,
    output logic              core_start,
    output logic [CH_W-1:0]   core_chan
);
    logic             launch;
    logic             done;
    logic [RES_W-1:0] res;
    logic [CH_W-1:0]  res_chan;
    logic [CH_W-1:0]  cfg_chan;
    logic             cfg_start;
    logic             cfg_single;
    logic             pwr_en;
    fe_state_e        state;

    adcfe_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CH_W(CH_W), .RES_W(RES_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .launch(launch), .done(done), .res(res), .res_chan(res_chan),
        .cfg_chan(cfg_chan), .cfg_start(cfg_start),
        .cfg_single(cfg_single), .pwr_en(pwr_en)
    );

    adcfe_seq #(
        .SETTLE_CYC(SETTLE_CYC)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .pwr_en(pwr_en), .start_req(cfg_start), .conv_done(done),
        .launch(launch), .state(state)
    );

    adcfe_conv_stub #(
        .LATENCY(CONV_LAT), .CH_W(CH_W), .RES_W(RES_W)
    ) u_stub (
        .clk(clk), .rst_n(rst_n),
        .pwr(pwr_en), .start(launch), .chan(cfg_chan), .sample(sample_in),
        .done(done), .res(res), .res_chan(res_chan)
    );

    assign core_pwr   = pwr_en;
    assign core_start = launch;
    assign core_chan  = launch ? cfg_chan : res_chan;

    // R7: channel select holds the launched channel while busy
    a_r7_chan_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BUSY && $past(state) == ST_BUSY) |-> $stable(core_chan));

endmodule

// File: tb/tb_adcfe_top.sv
module tb_adcfe_top;
    localparam int SETTLE = 6;
    localparam int LAT    = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [9:0]  sample_in = '0;
    logic        core_pwr;
    logic        core_start;
    logic [2:0]  core_chan;

    adcfe_top #(.SETTLE_CYC(SETTLE), .CONV_LAT(LAT)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sample_in(sample_in),
        .core_pwr(core_pwr), .core_start(core_start), .core_chan(core_chan)
    );

    always #5 clk = ~clk;

    int vectors = 0;
    int fails   = 0;
    int cyc     = 0;
    int starts  = 0;
    int pwr_cyc = 0;
    int gap     = -1;
    bit gap_armed = 0;
    bit done_flag = 0;
    logic [12:0] exp_q[$];

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: start pulses and settling gap
    always @(negedge clk) begin
        if (core_start) begin
            starts = starts + 1;
            if (gap_armed) begin
                gap = cyc - pwr_cyc;
                gap_armed = 0;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(posedge clk);
        #1;
        bus_we = 1'b0;
        if (a == 8'h10 && d[0]) begin
            pwr_cyc = cyc;
            gap = -1;
            gap_armed = 1;
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    // driver: request a single-shot conversion and push its expected result
    task automatic request(input logic [2:0] ch, input logic [9:0] code);
        sample_in = code;
        exp_q.push_back({ch, code});
        wr(8'h00, 32'h30 | 32'(ch));
    endtask

    // scoreboard check: poll completion, pop, compare
    task automatic collect(input string req);
        logic [31:0] v;
        logic [12:0] e;
        int n = 0;
        v = 0;
        while (n < 200) begin
            rd(8'h08, v);
            if (v[0]) break;
            n++;
        end
        chk({req, " eoc"}, v, 32'h1);
        if (exp_q.size() == 0) begin
            chk({req, " queue"}, 32'h0, 32'h1);
        end else begin
            e = exp_q.pop_front();
            rd(8'h04, v); chk({req, " data"}, v, {22'h0, e[9:0]});
            rd(8'h0C, v); chk({req, " sampled"}, v, {29'h0, e[12:10]});
        end
    endtask

    task automatic wait_gap(input string req);
        int n = 0;
        while (gap_armed && n < 60) begin
            @(posedge clk);
            n++;
        end
        chk(req, 32'(gap), 32'(SETTLE + 1));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done_flag) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int s0, s1;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(8'h00, v); chk("R1 cfg", v, 0);
        rd(8'h04, v); chk("R1 data", v, 0);
        rd(8'h08, v); chk("R1 eoc", v, 0);
        rd(8'h0C, v); chk("R1 samp", v, 0);
        rd(8'h10, v); chk("R1 pwr", v, 0);
        chk("R1 core_pwr", {31'h0, core_pwr}, 0);
        chk("R1 core_start", {31'h0, core_start}, 0);

        // R2 register map read-back, unused bits zero
        wr(8'h00, 32'hFFFF_FFEF);
        rd(8'h00, v); chk("R2 cfg mask", v, 32'h27);
        wr(8'h00, 32'h0);
        wr(8'h10, 32'hFFFF_FFFF);
        gap_armed = 0;
        rd(8'h10, v); chk("R2 pwr on", v, 32'h1);
        wr(8'h10, 32'h0);
        rd(8'h10, v); chk("R2 pwr off", v, 32'h0);
        rd(8'h14, v); chk("R2 unmapped 14", v, 0);
        rd(8'h20, v); chk("R2 unmapped 20", v, 0);

        // R9 writes to read-only or unmapped offsets
        wr(8'h04, 32'h3FF); wr(8'h08, 32'h1); wr(8'h0C, 32'h7); wr(8'h20, 32'hFFFF_FFFF);
        rd(8'h04, v); chk("R9 data", v, 0);
        rd(8'h08, v); chk("R9 eoc", v, 0);
        rd(8'h0C, v); chk("R9 samp", v, 0);
        rd(8'h00, v); chk("R9 cfg", v, 0);

        // R3 pending start before power-up, exact settling gap
        repeat (10) @(posedge clk);
        request(3'd2, 10'h155);
        repeat (10) @(posedge clk);
        chk("R3 no start while off", 32'(starts), 0);
        wr(8'h10, 32'h1);
        wait_gap("R3 settle gap");
        collect("R4 first");
        rd(8'h00, v); chk("R5 start cleared", v, 32'h22);

        // R4 flag clears at launch
        request(3'd5, 10'h2AA);
        @(posedge clk);
        rd(8'h08, v); chk("R4 eoc cleared", v, 0);
        collect("R4 second");

        // R7 rewrite channel mid-conversion
        request(3'd3, 10'h0F0);
        wr(8'h00, 32'h26);
        @(negedge clk);
        chk("R7 core_chan", {29'h0, core_chan}, 32'h3);
        collect("R7");
        rd(8'h00, v); chk("R7 cfg kept", v, 32'h26);

        // R6 continuous mode
        s0 = starts;
        wr(8'h00, 32'h11);
        repeat (4 * (LAT + 2)) @(posedge clk);
        chk("R6 repeated launches", 32'(starts - s0 >= 3), 1);
        rd(8'h00, v); chk("R6 start stays", v, 32'h11);
        wr(8'h00, 32'h01);
        repeat (LAT + 4) @(posedge clk);
        s1 = starts;
        repeat (3 * LAT) @(posedge clk);
        chk("R6 stop", 32'(starts), 32'(s1));

        // R8 power-down aborts conversion
        wr(8'h00, 32'h34);
        repeat (3) @(posedge clk);
        wr(8'h10, 32'h0);
        @(negedge clk);
        chk("R8 core_pwr", {31'h0, core_pwr}, 0);
        repeat (LAT + 5) @(posedge clk);
        rd(8'h08, v); chk("R8 eoc stays clear", v, 0);
        rd(8'h00, v); chk("R8 cfg", v, 32'h24);
        request(3'd1, 10'h3FF);
        wr(8'h10, 32'h1);
        wait_gap("R8 resettle gap");
        collect("R8 after repower");

        done_flag = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule